// File: doc/BRIEF.md
# Log-Domain Viterbi State Scorer

This block is the arithmetic core for scoring one frame of a left-to-right hidden Markov model. States enter one per clock. Each state brings its score from the previous frame, one log transition cost for each of its three possible predecessors (itself, the state just before it, and the state two places back), a mask saying which of those transitions exist, and a log observation cost. Scores are costs, so a smaller value is better. Each available candidate is formed by adding a transition cost to a stored predecessor score. The cheapest candidate is chosen and the observation cost is added to it. The new state score and the index of the winning predecessor leave the block two clocks after the state entered.

The predecessor scores are kept in a four-stage elastic store. Each stage is a two-way multiplexer in front of a register. Four control bits per state decide which stages load and which keep their contents. This lets self-loop, skip and irregular topologies share one datapath. A frame-start pulse refills the store with the worst cost before the first state of a frame. The oldest store stage is brought out so that identical elements can be chained into a linear pipeline. All additions saturate at the all-ones cost and never wrap.

Top module: `hmm_viterbi_pe`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following cycle shows `out_valid`=0, `out_score`=0, `out_src`=0, and all store stages at the all-ones cost (visible on `store_tail`).
- R2: A cycle with `state_valid`=1 and `frame_start`=0 produces `out_valid`=1 exactly two cycles later. `out_valid` is never high otherwise.
- R3: Every addition (stored score plus transition cost, and best plus observation cost) saturates at all-ones instead of wrapping.
- R4: `cand_en` bit 0 enables self, bit 1 previous and bit 2 skip. A disabled candidate counts as all-ones cost. With every candidate disabled, the score is all-ones and `out_src` is 0.
- R5: The cheapest candidate wins. On a tie the lowest index wins. `out_src` encodes self=0, previous=1, skip=2 and never shows 3.
- R6: `out_score` equals the winning candidate total plus `obs_cost` (saturated).
- R7: On an accepted state, stage 0 loads `prev_score` if `store_ctrl[0]`=1, and stage k (k=1..3) loads stage k-1 if `store_ctrl[k]`=1. A stage whose bit is 0 keeps its contents. Candidates use the values after this update: self from stage 0, previous from stage 1, skip from stage 2.
- R8: `frame_start`=1 sets all four stages to all-ones on the next edge. A state presented in the same cycle is dropped and produces no output.
- R9: `store_tail` shows stage 3 and is updated by the same edge as the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | Clears the predecessor store to worst cost |
| state_valid | input | 1 | A state is presented this cycle |
| prev_score | input | SCORE_W | Previous-frame score of the presented state |
| cost_self | input | SCORE_W | Log cost of the self-loop transition |
| cost_prev | input | SCORE_W | Log cost from the preceding state |
| cost_skip | input | SCORE_W | Log cost from the state two back |
| cand_en | input | 3 | Per-candidate enable (bit 0 self, 1 previous, 2 skip) |
| store_ctrl | input | 4 | Per-stage load enable of the elastic store |
| obs_cost | input | SCORE_W | Log observation cost of the state |
| out_valid | output | 1 | New score valid |
| out_score | output | SCORE_W | New state score |
| out_src | output | 2 | Index of the winning predecessor |
| store_tail | output | SCORE_W | Oldest store stage, for cascading |

## Verification
The bench builds the block with the default SCORE_W of 16. This keeps saturation reachable with ordinary vectors: stored scores near 0xFFFF, all-ones transition costs and large observation costs all hit the clamp. A fixed vector table walks a three-state left-to-right frame and a frame with skip transitions. The same table covers held stages, ties and fully masked states. A streamed run with random costs, random store controls and occasional frame starts is compared against a behavioural reference inside the bench.

// File: rtl/hmm_pe_pkg.sv
// Shared constants for the Viterbi scoring element.
// Assumes exactly three predecessor candidates and a four-stage store.
package hmm_pe_pkg;
    localparam int NUM_CAND     = 3;
    localparam int STORE_STAGES = 4;
    localparam int SRC_W        = $clog2(NUM_CAND);

    typedef enum logic [SRC_W-1:0] {
        SRC_SELF = 2'd0,
        SRC_PREV = 2'd1,
        SRC_SKIP = 2'd2
    } src_e;
endpackage

// File: rtl/elastic_store.sv
// Predecessor score store: a chain of STAGES registers, each fed by a
// two-way multiplexer that picks between a new value and its own contents.
// Stage 0 takes the external score, stage k takes stage k-1.
// Assumes clear has priority over shift; reset fills every stage with worst cost.
module elastic_store #(
    parameter int W      = 16,
    parameter int STAGES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      shift,
    input  logic [W-1:0]              din,
    input  logic [STAGES-1:0]         ctrl,
    output logic [STAGES-1:0][W-1:0]  stage_q
);
    localparam logic [W-1:0] WORST = '1;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        logic [W-1:0] src;
        if (k == 0) begin : g_head
            assign src = din;
        end else begin : g_body
            assign src = stage_q[k-1];
        end

        // One stage: clear to worst, else load the source when enabled, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                stage_q[k] <= WORST;
            end else if (shift && ctrl[k]) begin
                stage_q[k] <= src;
            end
        end
    end
endmodule

// File: rtl/cand_select.sv
// Combinational add-compare-add: forms each candidate as a saturated sum of
// stored score and transition cost, forces masked candidates to worst cost,
// keeps the cheapest (lowest index on ties), then adds the observation cost.
module cand_select #(
    parameter int W     = 16,
    parameter int NCAND = 3,
    parameter int IDX_W = 2
) (
    input  logic [NCAND-1:0][W-1:0] stored,
    input  logic [NCAND-1:0][W-1:0] cost,
    input  logic [NCAND-1:0]        en,
    input  logic [W-1:0]            obs,
    output logic [W-1:0]            score,
    output logic [IDX_W-1:0]        win
);
    localparam logic [W-1:0] WORST = '1;

    function automatic logic [W-1:0] sat_add(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[W] ? WORST : s[W-1:0];
    endfunction

    logic [NCAND-1:0][W-1:0] total;
    logic [W-1:0]            best;

    // Candidate totals with masking.
    always_comb begin
        for (int i = 0; i < NCAND; i++) begin
            total[i] = en[i] ? sat_add(stored[i], cost[i]) : WORST;
        end
    end

    // Linear scan with strict compare so the lowest index keeps a tie.
    always_comb begin
        best = total[0];
        win  = '0;
        for (int i = 1; i < NCAND; i++) begin
            if (total[i] < best) begin
                best = total[i];
                win  = IDX_W'(i);
            end
        end
    end

    // Observation cost added after the compare.
    assign score = sat_add(best, obs);
endmodule

// File: rtl/hmm_viterbi_pe.sv
// Viterbi scoring element for left-to-right models. One state per clock;
// result two clocks later. Edge 1 updates the store and registers the costs,
// edge 2 registers the compared and observed score.
// Assumes frame_start is pulsed in a cycle with no state to keep.
module hmm_viterbi_pe
    import hmm_pe_pkg::*;
#(
    parameter int SCORE_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic                 state_valid,
    input  logic [SCORE_W-1:0]   prev_score,
    input  logic [SCORE_W-1:0]   cost_self,
    input  logic [SCORE_W-1:0]   cost_prev,
    input  logic [SCORE_W-1:0]   cost_skip,
    input  logic [NUM_CAND-1:0]  cand_en,
    input  logic [STORE_STAGES-1:0] store_ctrl,
    input  logic [SCORE_W-1:0]   obs_cost,
    output logic                 out_valid,
    output logic [SCORE_W-1:0]   out_score,
    output logic [SRC_W-1:0]     out_src,
    output logic [SCORE_W-1:0]   store_tail
);
    logic                                accept;
    logic [STORE_STAGES-1:0][SCORE_W-1:0] store_q;
    logic [NUM_CAND-1:0][SCORE_W-1:0]     cost_q;
    logic [NUM_CAND-1:0]                  en_q;
    logic [SCORE_W-1:0]                   obs_q;
    logic                                 vld_q;
    logic [SCORE_W-1:0]                   sel_score;
    logic [SRC_W-1:0]                     sel_win;

    assign accept = state_valid && !frame_start;

    elastic_store #(.W(SCORE_W), .STAGES(STORE_STAGES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (frame_start),
        .shift   (accept),
        .din     (prev_score),
        .ctrl    (store_ctrl),
        .stage_q (store_q)
    );

    // First pipeline register: costs and mask travel alongside the store update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            cost_q <= '0;
            en_q   <= '0;
            obs_q  <= '0;
        end else begin
            vld_q <= accept;
            if (accept) begin
                cost_q <= {cost_skip, cost_prev, cost_self};
                en_q   <= cand_en;
                obs_q  <= obs_cost;
            end
        end
    end

    cand_select #(.W(SCORE_W), .NCAND(NUM_CAND), .IDX_W(SRC_W)) u_sel (
        .stored (store_q[NUM_CAND-1:0]),
        .cost   (cost_q),
        .en     (en_q),
        .obs    (obs_q),
        .score  (sel_score),
        .win    (sel_win)
    );

    // Second pipeline register: the published score and winning source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_score <= '0;
            out_src   <= SRC_SELF;
        end else begin
            out_valid <= vld_q;
            if (vld_q) begin
                out_score <= sel_score;
                out_src   <= sel_win;
            end
        end
    end

    assign store_tail = store_q[STORE_STAGES-1];
endmodule

// File: rtl/hmm_viterbi_pe_checker.sv
// Protocol and datapath properties of the scoring element, bound to its ports.
module hmm_viterbi_pe_checker #(
    parameter int SCORE_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               frame_start,
    input logic               state_valid,
    input logic [2:0]         cand_en,
    input logic               out_valid,
    input logic [1:0]         out_src,
    input logic [SCORE_W-1:0] store_tail
);
    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_valid && !frame_start) |-> ##2 out_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(state_valid && !frame_start, 2));

    assert_src_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_src != 2'd3));

    assert_frame_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (store_tail == {SCORE_W{1'b1}}));

    assert_masked_self_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_valid && !frame_start && cand_en == 3'b001) |-> ##2 (out_src == 2'd0));
endmodule

bind hmm_viterbi_pe hmm_viterbi_pe_checker #(.SCORE_W(SCORE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .state_valid (state_valid),
    .cand_en     (cand_en),
    .out_valid   (out_valid),
    .out_src     (out_src),
    .store_tail  (store_tail)
);

// File: tb/hmm_viterbi_pe_bench.sv
// Self-checking bench: vector table, directed corner cases, random stream
// against a behavioural reference.
module hmm_viterbi_pe_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W          = 16;
    localparam int NSTREAM    = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic state_valid = 1'b0;
    logic [W-1:0] prev_score = '0, cost_self = '0, cost_prev = '0, cost_skip = '0, obs_cost = '0;
    logic [2:0] cand_en = '0;
    logic [3:0] store_ctrl = '0;
    logic out_valid;
    logic [W-1:0] out_score;
    logic [1:0] out_src;
    logic [W-1:0] store_tail;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hmm_viterbi_pe #(.SCORE_W(W)) u_hmm_viterbi_pe (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .state_valid(state_valid),
        .prev_score(prev_score), .cost_self(cost_self), .cost_prev(cost_prev),
        .cost_skip(cost_skip), .cand_en(cand_en), .store_ctrl(store_ctrl),
        .obs_cost(obs_cost), .out_valid(out_valid), .out_score(out_score),
        .out_src(out_src), .store_tail(store_tail)
    );

    typedef struct packed {
        logic         fs;
        logic         vld;
        logic [15:0]  ins;
        logic [15:0]  ts;
        logic [15:0]  tp;
        logic [15:0]  tk;
        logic [2:0]   en;
        logic [3:0]   ctrl;
        logic [15:0]  obs;
        logic [15:0]  exp_s;
        logic [1:0]   exp_i;
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS[NVEC] = '{
        '{1'b1, 1'b0, 16'd0,     16'd0,   16'd0,      16'd0,      3'b000, 4'hF,    16'd0,      16'd0,      2'd0},
        '{1'b0, 1'b1, 16'd100,   16'd5,   16'd7,      16'd9,      3'b001, 4'hF,    16'd10,     16'd115,    2'd0},
        '{1'b0, 1'b1, 16'd200,   16'd5,   16'd3,      16'd9,      3'b011, 4'hF,    16'd4,      16'd107,    2'd1},
        '{1'b0, 1'b1, 16'd50,    16'd60,  16'd51,     16'd9,      3'b011, 4'hF,    16'd1,      16'd111,    2'd0},
        '{1'b1, 1'b0, 16'd0,     16'd0,   16'd0,      16'd0,      3'b000, 4'hF,    16'd0,      16'd0,      2'd0},
        '{1'b0, 1'b1, 16'd5,     16'd100, 16'd0,      16'd0,      3'b111, 4'hF,    16'd0,      16'd105,    2'd0},
        '{1'b1, 1'b0, 16'd0,     16'd0,   16'd0,      16'd0,      3'b000, 4'hF,    16'd0,      16'd0,      2'd0},
        '{1'b0, 1'b1, 16'd30,    16'd2,   16'd0,      16'd0,      3'b001, 4'hF,    16'd3,      16'd35,     2'd0},
        '{1'b0, 1'b1, 16'd40,    16'd10,  16'd5,      16'd0,      3'b011, 4'hF,    16'd0,      16'd35,     2'd1},
        '{1'b0, 1'b1, 16'd90,    16'd1,   16'd20,     16'd4,      3'b111, 4'hF,    16'd2,      16'd36,     2'd2},
        '{1'b0, 1'b1, 16'd10,    16'd30,  16'd60,     16'd0,      3'b111, 4'hF,    16'd0,      16'd40,     2'd0},
        '{1'b0, 1'b1, 16'hFFF0,  16'h20,  16'hFFFF,   16'hFFFF,   3'b001, 4'hF,    16'd5,      16'hFFFF,   2'd0},
        '{1'b0, 1'b1, 16'd7,     16'd100, 16'd1,      16'd1,      3'b111, 4'b0001, 16'd0,      16'd11,     2'd1},
        '{1'b0, 1'b1, 16'd500,   16'd0,   16'd0,      16'd0,      3'b111, 4'b1110, 16'd0,      16'd7,      2'd0},
        '{1'b0, 1'b1, 16'd3,     16'd0,   16'd0,      16'd0,      3'b000, 4'b0000, 16'd0,      16'hFFFF,   2'd0},
        '{1'b0, 1'b1, 16'd3,     16'd1,   16'd0,      16'd0,      3'b001, 4'b0000, 16'hFFFA,   16'hFFFF,   2'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic fs, input logic vld, input logic [W-1:0] ins,
                         input logic [W-1:0] ts, input logic [W-1:0] tp, input logic [W-1:0] tk,
                         input logic [2:0] en, input logic [3:0] ctrl, input logic [W-1:0] obs);
        frame_start = fs; state_valid = vld; prev_score = ins;
        cost_self = ts; cost_prev = tp; cost_skip = tk;
        cand_en = en; store_ctrl = ctrl; obs_cost = obs;
    endtask

    task automatic idle();
        drive(1'b0, 1'b0, '0, '0, '0, '0, 3'b000, 4'h0, '0);
    endtask

    // Behavioural reference
    logic [W-1:0] m_st[4];

    function automatic logic [W-1:0] ref_add(input logic [W-1:0] a, input logic [W-1:0] b);
        int unsigned s;
        s = int'(a) + int'(b);
        return (s > 32'hFFFF) ? 16'hFFFF : s[15:0];
    endfunction

    task automatic model(input logic fs, input logic vld, input logic [W-1:0] ins,
                         input logic [W-1:0] ts, input logic [W-1:0] tp, input logic [W-1:0] tk,
                         input logic [2:0] en, input logic [3:0] ctrl, input logic [W-1:0] obs,
                         output logic ev, output logic [W-1:0] es, output logic [1:0] ei);
        logic [W-1:0] c[3];
        logic [W-1:0] b;
        ev = 1'b0; es = '0; ei = 2'd0;
        if (fs) begin
            for (int k = 0; k < 4; k++) m_st[k] = 16'hFFFF;
        end else if (vld) begin
            for (int k = 3; k >= 1; k--) if (ctrl[k]) m_st[k] = m_st[k-1];
            if (ctrl[0]) m_st[0] = ins;
            c[0] = en[0] ? ref_add(m_st[0], ts) : 16'hFFFF;
            c[1] = en[1] ? ref_add(m_st[1], tp) : 16'hFFFF;
            c[2] = en[2] ? ref_add(m_st[2], tk) : 16'hFFFF;
            b = c[0];
            if (c[1] < b) begin b = c[1]; ei = 2'd1; end
            if (c[2] < b) begin b = c[2]; ei = 2'd2; end
            es = ref_add(b, obs);
            ev = 1'b1;
        end
    endtask

    function automatic logic [W-1:0] rnd_val();
        int unsigned r;
        r = $urandom % 4;
        return (r == 0) ? (16'hFF00 | 16'($urandom)) : (16'($urandom) & 16'h0FFF);
    endfunction

    logic         s_v[NSTREAM];
    logic [W-1:0] s_s[NSTREAM];
    logic [1:0]   s_i[NSTREAM];

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 out_valid", 32'(out_valid), 32'd0);
        chk("R1 out_score", 32'(out_score), 32'd0);
        chk("R1 out_src", 32'(out_src), 32'd0);
        chk("R1 store_tail", 32'(store_tail), 32'hFFFF);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NVEC; v++) begin
            @(negedge clk);
            drive(VECS[v].fs, VECS[v].vld, VECS[v].ins, VECS[v].ts, VECS[v].tp, VECS[v].tk,
                  VECS[v].en, VECS[v].ctrl, VECS[v].obs);
            @(negedge clk);
            idle();
            @(negedge clk);
            chk("R2 valid after two cycles", 32'(out_valid), 32'(VECS[v].vld));
            if (VECS[v].vld) begin
                chk("R6/R7 score", 32'(out_score), 32'(VECS[v].exp_s));
                chk("R5 source", 32'(out_src), 32'(VECS[v].exp_i));
            end
        end
        // R9: tail holds stage 3 after held-stage rows
        chk("R9 tail", 32'(store_tail), 32'd90);

        // R8: frame start clears, tail shows worst one edge later
        @(negedge clk);
        drive(1'b1, 1'b0, '0, '0, '0, '0, 3'b000, 4'h0, '0);
        @(negedge clk);
        idle();
        chk("R8 clear tail", 32'(store_tail), 32'hFFFF);

        // R8: a state together with frame start is dropped
        @(negedge clk);
        drive(1'b1, 1'b1, 16'd1, 16'd1, 16'd1, 16'd1, 3'b111, 4'hF, 16'd1);
        @(negedge clk);
        idle();
        @(negedge clk);
        chk("R8 dropped state", 32'(out_valid), 32'd0);

        // R1: reset in flight suppresses a pending result
        @(negedge clk);
        drive(1'b0, 1'b1, 16'd4, 16'd4, 16'd4, 16'd4, 3'b111, 4'hF, 16'd4);
        @(negedge clk);
        idle();
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid reset valid", 32'(out_valid), 32'd0);
        chk("R1 mid reset tail", 32'(store_tail), 32'hFFFF);
        rst_n = 1'b1;

        // Random stream against the reference (R2..R7)
        for (int k = 0; k < 4; k++) m_st[k] = 16'hFFFF;
        for (int k = 0; k < NSTREAM + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                chk("R2 stream valid", 32'(out_valid), 32'(s_v[k-2]));
                if (s_v[k-2]) begin
                    chk("R3/R6 stream score", 32'(out_score), 32'(s_s[k-2]));
                    chk("R4/R5 stream source", 32'(out_src), 32'(s_i[k-2]));
                end
            end
            if (k < NSTREAM) begin
                logic fs, vld;
                logic [W-1:0] ins, ts, tp, tk, obs;
                logic [2:0] en;
                logic [3:0] ctrl;
                fs  = (($urandom % 20) == 0);
                vld = !fs && (($urandom % 4) != 0);
                ins = rnd_val(); ts = rnd_val(); tp = rnd_val(); tk = rnd_val(); obs = rnd_val();
                en  = 3'($urandom);
                ctrl = (($urandom % 3) == 0) ? 4'($urandom) : 4'hF;
                drive(fs, vld, ins, ts, tp, tk, en, ctrl, obs);
                model(fs, vld, ins, ts, tp, tk, en, ctrl, obs, s_v[k], s_s[k], s_i[k]);
            end else begin
                idle();
            end
        end
        finish_run();
    end
endmodule